// File: doc/BRIEF.md
# Cascade ID Steering Unit for a Priority Interrupt Controller

This block lets several interrupt controllers share one interrupt line and act as one larger system. One controller acts as master and up to eight act as slaves, which gives 64 request levels in total. They are linked by a private three-line cascade bus. During an acknowledge sequence, the master latches the level chosen by its priority logic. If a slave is wired to that request input, the master places the level on the cascade lines as a slave ID. A slave compares the cascade lines with its programmed ID on each vector pulse. It drives the data bus only when the two are equal.

The role comes from a strap input while buffered operation is off. While buffered operation is on, software sets the role, and the strap pin turns into an output that enables the external data bus transceivers. The sequence is two acknowledge pulses long, or three when an opcode byte comes before the vector. The unit only decides who drives and when. The vector contents and the priority decision come from neighbouring logic.

Top module: `cascade_id_unit`

## Requirements
- R1: `role_master` equals `strap_master` while `cfg_buffered` is 0, and equals `cfg_sw_master` while it is 1. `cas_oe` always equals `role_master`.
- R2: At the sampled rising edge of the first `ack` pulse, the unit latches `req_level`. Later changes of `req_level` have no effect until the next sequence. From the next clock until the sequence ends, a master whose `cfg_slave_map` bit for the latched level is 1 drives that level on `cas_out`.
- R3: `cas_out` is 0 when idle, when the latched level has no slave (map bit 0), and whenever the role is slave.
- R4: `ack` is sampled on every clock, and each 0-to-1 transition starts a pulse. A sequence is 2 pulses long when `cfg_three_pulse` is 0 and 3 pulses long when it is 1. It ends when `ack` falls after the last pulse. Further rises beyond the last pulse do not advance the count.
- R5: A slave asserts `vec_drive` during vector pulses only. The vector pulses are pulse 2 in two-pulse mode, and pulses 2 and 3 in three-pulse mode. The slave asserts it only if `cas_in` equaled `cfg_own_id` at that pulse's rising edge. Outputs follow the registered `ack` one clock late.
- R6: A master asserts `vec_drive` during vector pulses only when the latched level has no slave. For a mapped level it never drives the vector.
- R7: In three-pulse mode, a master asserts `op_drive` during pulse 1. In two-pulse mode, and on any slave, `op_drive` stays 0.
- R8: `data_oe` is the OR of `vec_drive`, `op_drive` and `rd_status`.
- R9: With `cfg_buffered` = 1, `sp_oe` is 1 and `xcvr_en` equals `data_oe`. With `cfg_buffered` = 0, both are 0.
- R10: After reset the unit is idle: `cas_out` = 0, `vec_drive` = 0 and `op_drive` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| strap_master | input | 1 | role strap value read from the shared pin (1 = master) |
| cfg_buffered | input | 1 | buffered operation enable |
| cfg_sw_master | input | 1 | role chosen by software in buffered operation |
| cfg_three_pulse | input | 1 | 1 = opcode pulse plus two vector pulses |
| cfg_slave_map | input | 8 | one bit per request input: a slave hangs there |
| cfg_own_id | input | 3 | slave identity |
| req_level | input | 3 | level chosen by the priority logic |
| ack | input | 1 | acknowledge pulse, active high |
| rd_status | input | 1 | a status read is driving the data bus |
| cas_in | input | 3 | cascade lines as received |
| cas_out | output | 3 | cascade lines as driven |
| cas_oe | output | 1 | cascade line driver enable |
| role_master | output | 1 | current role |
| sp_oe | output | 1 | shared pin acts as output |
| xcvr_en | output | 1 | transceiver enable on the shared pin |
| vec_drive | output | 1 | drive the vector byte now |
| op_drive | output | 1 | drive the opcode byte now |
| data_oe | output | 1 | data bus driven by this unit |

## Verification
The bench changes `req_level` in the middle of a sequence. A design that did not latch the level at the first rise would send the wrong slave ID or give up the vector wrongly. It also changes `cas_in` between the two vector pulses of a three-pulse sequence. Here a slave that matched once and kept the match would drive the bus on a pulse that belongs to another slave. Extra `ack` pulses are sent after the last pulse, and the pulse length is switched between sequences. A counter that ran on, or ended at the wrong pulse, would leave the vector enabled or drop it early. Buffered operation is toggled while status reads are in progress. A wrong enable on the shared pin shows as a mismatch on `xcvr_en` or `sp_oe`.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

    localparam int ID_W     = 3;
    localparam int N_INPUTS = 1 << ID_W;
    localparam int PULSE_W  = 2;

    typedef logic [ID_W-1:0]    cas_id_t;
    typedef logic [PULSE_W-1:0] pulse_idx_t;

    typedef struct packed {
        logic       ack_q;
        pulse_idx_t pulse_no;
    } seq_state_t;

    function automatic pulse_idx_t final_pulse(input logic three);
        return three ? pulse_idx_t'(3) : pulse_idx_t'(2);
    endfunction

endpackage

// File: rtl/cas_role_sel.sv
module cas_role_sel (
    input  logic strap_master,
    input  logic cfg_buffered,
    input  logic cfg_sw_master,
    input  logic data_oe,
    output logic role_master,
    output logic sp_oe,
    output logic xcvr_en
);
    always_comb begin
        role_master = cfg_buffered ? cfg_sw_master : strap_master;
        sp_oe       = cfg_buffered;
        xcvr_en     = cfg_buffered & data_oe;
    end
endmodule

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
    import cascade_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack,
    input  logic       cfg_three_pulse,
    output seq_state_t seq,
    output logic       first_rise,
    output logic       vec_rise
);
    logic       rise;
    logic       fall;
    logic       advance;
    pulse_idx_t last_no;

    always_comb begin
        last_no    = final_pulse(cfg_three_pulse);
        rise       = ack & ~seq.ack_q;
        fall       = ~ack & seq.ack_q;
        advance    = rise && (seq.pulse_no < last_no);
        first_rise = advance && (seq.pulse_no == '0);
        vec_rise   = advance && (seq.pulse_no != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq <= '0;
        end else begin
            seq.ack_q <= ack;
            if (advance)
                seq.pulse_no <= seq.pulse_no + pulse_idx_t'(1);
            else if (fall && seq.pulse_no == last_no)
                seq.pulse_no <= '0;
        end
    end
endmodule

// File: rtl/cas_id_path.sv
module cas_id_path
    import cascade_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                first_rise,
    input  logic                vec_rise,
    input  seq_state_t          seq,
    input  logic                role_master,
    input  cas_id_t             req_level,
    input  cas_id_t             cas_in,
    input  cas_id_t             cfg_own_id,
    input  logic [N_INPUTS-1:0] cfg_slave_map,
    output cas_id_t             cas_out,
    output logic                vec_drive
);
    cas_id_t lvl_q;
    logic    hit_q;
    logic    lvl_has_slave;
    logic    vec_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            hit_q <= 1'b0;
        end else begin
            if (first_rise) lvl_q <= req_level;
            if (vec_rise)   hit_q <= (cas_in == cfg_own_id);
        end
    end

    always_comb begin
        lvl_has_slave = cfg_slave_map[lvl_q];
        vec_pulse     = seq.ack_q && (seq.pulse_no >= pulse_idx_t'(2));
        cas_out       = (role_master && lvl_has_slave && seq.pulse_no != '0) ? lvl_q : '0;
        vec_drive     = vec_pulse && (role_master ? ~lvl_has_slave : hit_q);
    end
endmodule

// File: rtl/cascade_id_unit.sv
module cascade_id_unit
    import cascade_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                strap_master,
    input  logic                cfg_buffered,
    input  logic                cfg_sw_master,
    input  logic                cfg_three_pulse,
    input  logic [N_INPUTS-1:0] cfg_slave_map,
    input  logic [ID_W-1:0]     cfg_own_id,
    input  logic [ID_W-1:0]     req_level,
    input  logic                ack,
    input  logic                rd_status,
    input  logic [ID_W-1:0]     cas_in,
    output logic [ID_W-1:0]     cas_out,
    output logic                cas_oe,
    output logic                role_master,
    output logic                sp_oe,
    output logic                xcvr_en,
    output logic                vec_drive,
    output logic                op_drive,
    output logic                data_oe
);
    seq_state_t seq;
    logic       first_rise;
    logic       vec_rise;

    cas_ack_seq u_seq (
        .clk             (clk),
        .rst             (rst),
        .ack             (ack),
        .cfg_three_pulse (cfg_three_pulse),
        .seq             (seq),
        .first_rise      (first_rise),
        .vec_rise        (vec_rise)
    );

    cas_id_path u_path (
        .clk           (clk),
        .rst           (rst),
        .first_rise    (first_rise),
        .vec_rise      (vec_rise),
        .seq           (seq),
        .role_master   (role_master),
        .req_level     (req_level),
        .cas_in        (cas_in),
        .cfg_own_id    (cfg_own_id),
        .cfg_slave_map (cfg_slave_map),
        .cas_out       (cas_out),
        .vec_drive     (vec_drive)
    );

    cas_role_sel u_role (
        .strap_master  (strap_master),
        .cfg_buffered  (cfg_buffered),
        .cfg_sw_master (cfg_sw_master),
        .data_oe       (data_oe),
        .role_master   (role_master),
        .sp_oe         (sp_oe),
        .xcvr_en       (xcvr_en)
    );

    always_comb begin
        op_drive = seq.ack_q && cfg_three_pulse && role_master
                   && (seq.pulse_no == pulse_idx_t'(1));
        data_oe  = vec_drive | op_drive | rd_status;
        cas_oe   = role_master;
    end
endmodule

// File: rtl/cascade_id_checker.sv
module cascade_id_checker
    import cascade_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cfg_buffered,
    input logic            cfg_three_pulse,
    input logic            rd_status,
    input logic [ID_W-1:0] cas_out,
    input logic            cas_oe,
    input logic            role_master,
    input logic            xcvr_en,
    input logic            vec_drive,
    input logic            op_drive,
    input logic            data_oe
);
    // R3
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !role_master |-> cas_out == '0);

    // R9
    unbuf_en_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_buffered |-> !xcvr_en);

    // R7
    op_owner_chk: assert property (@(posedge clk) disable iff (rst)
        op_drive |-> (cfg_three_pulse && role_master));

    // R6
    master_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_drive && role_master) |-> cas_out == '0);

    // R1
    cas_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (cas_out != '0) |-> cas_oe);

    // R8
    bus_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_drive || op_drive || rd_status) |-> data_oe);

    // R5
    no_dual_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !(vec_drive && op_drive));
endmodule

bind cascade_id_unit cascade_id_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_buffered    (cfg_buffered),
    .cfg_three_pulse (cfg_three_pulse),
    .rd_status       (rd_status),
    .cas_out         (cas_out),
    .cas_oe          (cas_oe),
    .role_master     (role_master),
    .xcvr_en         (xcvr_en),
    .vec_drive       (vec_drive),
    .op_drive        (op_drive),
    .data_oe         (data_oe)
);

// File: tb/cascade_id_unit_bench.sv
`timescale 1ns/1ps
module cascade_id_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_master = 1'b1;
    logic       cfg_buffered = 1'b0;
    logic       cfg_sw_master = 1'b0;
    logic       cfg_three_pulse = 1'b0;
    logic [7:0] cfg_slave_map = 8'h00;
    logic [2:0] cfg_own_id = 3'd0;
    logic [2:0] req_level = 3'd0;
    logic       ack = 1'b0;
    logic       rd_status = 1'b0;
    logic [2:0] cas_in = 3'd0;
    logic [2:0] cas_out;
    logic       cas_oe, role_master, sp_oe, xcvr_en, vec_drive, op_drive, data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_ackq = 0, m_pn = 0, m_lvl = 0, m_sel = 0;

    always #2.5 clk = ~clk;

    cascade_id_unit u_cascade_id_unit (
        .clk(clk), .rst(rst), .strap_master(strap_master),
        .cfg_buffered(cfg_buffered), .cfg_sw_master(cfg_sw_master),
        .cfg_three_pulse(cfg_three_pulse), .cfg_slave_map(cfg_slave_map),
        .cfg_own_id(cfg_own_id), .req_level(req_level), .ack(ack),
        .rd_status(rd_status), .cas_in(cas_in), .cas_out(cas_out),
        .cas_oe(cas_oe), .role_master(role_master), .sp_oe(sp_oe),
        .xcvr_en(xcvr_en), .vec_drive(vec_drive), .op_drive(op_drive),
        .data_oe(data_oe)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        int last;
        last = cfg_three_pulse ? 3 : 2;
        if (rst) begin
            m_ackq = 0; m_pn = 0; m_lvl = 0; m_sel = 0;
        end else begin
            if (ack && !m_ackq && m_pn < last) begin
                if (m_pn == 0) m_lvl = req_level;
                m_pn++;
                if (m_pn >= 2) m_sel = (cas_in == cfg_own_id);
            end else if (!ack && m_ackq && m_pn == last) begin
                m_pn = 0;
            end
            m_ackq = ack;
        end
    endtask

    task automatic compare_all();
        int mst, mapped, e_cas, e_vec, e_op, e_doe;
        mst    = cfg_buffered ? cfg_sw_master : strap_master;
        mapped = cfg_slave_map[m_lvl];
        e_cas  = (m_pn != 0 && mst && mapped) ? m_lvl : 0;
        e_vec  = (m_ackq && m_pn >= 2) ? (mst ? !mapped : m_sel) : 0;
        e_op   = (m_ackq && cfg_three_pulse && m_pn == 1 && mst) ? 1 : 0;
        e_doe  = e_vec | e_op | rd_status;
        check("R1 role", role_master, mst);
        check("R1 cas_oe", cas_oe, mst);
        check("R2/R3 cas_out", cas_out, e_cas);
        check("R5/R6 vec_drive", vec_drive, e_vec);
        check("R7 op_drive", op_drive, e_op);
        check("R8 data_oe", data_oe, e_doe);
        check("R9 sp_oe", sp_oe, cfg_buffered);
        check("R9 xcvr_en", xcvr_en, cfg_buffered & e_doe);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare_all();
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            ack = 1'b1; step(); step();
            ack = 1'b0; step(); step();
        end
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        // R10 reset state
        check("R10 cas_out", cas_out, 0);
        check("R10 vec_drive", vec_drive, 0);
        check("R10 op_drive", op_drive, 0);

        // R2 master, mapped level 5, two-pulse
        cfg_slave_map = 8'b0010_0100;
        req_level = 3'd5;
        pulses(1);
        check("R2 cas after pulse1", cas_out, 5);
        req_level = 3'd2;            // R2 mid-sequence change ignored
        pulses(1);
        check("R4 idle after two", cas_out, 0);

        // R6 master, unmapped level, two-pulse
        req_level = 3'd3;
        pulses(2);
        // R2/R3 mapped level changed away mid sequence
        req_level = 3'd2; ack = 1'b1; step(); step();
        req_level = 3'd3; ack = 1'b0; step(); step();
        pulses(1);

        // R7 three-pulse master, unmapped then mapped
        cfg_three_pulse = 1'b1;
        req_level = 3'd0;
        pulses(3);
        req_level = 3'd5;
        pulses(3);
        // R4 extra pulses after last: start a new sequence
        pulses(5);
        pulses(1);

        // R5 slave role
        cfg_three_pulse = 1'b0;
        strap_master = 1'b0;
        cfg_own_id = 3'd4;
        cas_in = 3'd4;
        pulses(2);
        cas_in = 3'd6;
        pulses(2);
        // R5 three-pulse, match on pulse 2 only
        cfg_three_pulse = 1'b1;
        pulses(1);
        cas_in = 3'd4; pulses(1);
        cas_in = 3'd1; pulses(1);
        cas_in = 3'd4; pulses(3);

        // R9 buffered mode, software role, status reads
        cfg_buffered = 1'b1;
        cfg_sw_master = 1'b1;
        rd_status = 1'b1; step(); step();
        check("R9 xcvr_en on read", xcvr_en, 1);
        rd_status = 1'b0; step();
        req_level = 3'd3;
        pulses(3);
        cfg_sw_master = 1'b0;
        cas_in = 3'd4;
        pulses(3);
        rd_status = 1'b1; step();
        cfg_buffered = 1'b0; step();
        check("R9 no enable unbuffered", xcvr_en, 0);
        rd_status = 1'b0;
        // R1 strap follows when unbuffered
        strap_master = 1'b1; step();
        check("R1 strap master", role_master, 1);

        // R10 reset mid-sequence
        ack = 1'b1; step(); step();
        rst = 1'b1; step();
        ack = 1'b0; step();
        rst = 1'b0; step();
        check("R10 after reset", cas_out + vec_drive + op_drive, 0);
        step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule